// File: doc/BRIEF.md
# Slow Clock Source Switch Sequencer

This block selects the slow clock for the always-on domain. After a backup-domain reset the output runs from the internal RC oscillator and only the RC oscillator is enabled. Software issues a one-cycle select command with the crystal bit set. The block then runs a fixed, one-way sequence:

1. It enables the crystal oscillator.
2. It waits a parameterised number of RC clock periods so that the crystal can start up.
3. It moves the output clock to the crystal glitch-free, holding the output low while neither source is gated through.
4. It switches the RC oscillator off and raises a status flag.

A bypass mode is also available. It is meant for an external clock fed into the crystal input instead of a crystal. In that mode the crystal amplifier stays disabled and the start-up wait is skipped. Once the crystal is the source, nothing except the asynchronous reset brings the RC oscillator back. The command interface is sampled on the rising edge of the RC clock.

Top module: `slow_clk_switch`

## Requirements
- R1: While reset is asserted and after its release, rc_en_o is 1, xt_en_o is 0, xt_sel_o is 0, and clk_o follows rc_clk_i.
- R2: A command (cmd_we_i=1) with cmd_xtal_i=1 and bypass_i=0, sampled on a rising RC edge, sets xt_en_o from that edge on. A command with cmd_xtal_i=0 has no effect.
- R3: In non-bypass mode, clk_o keeps following rc_clk_i for exactly START_CYCLES rising RC edges after the command edge. xt_sel_o stays 0 during that time and for at least one further edge.
- R4: The handoff is break-before-make. The RC and crystal gates are never both open. The output is low during the high half of the first RC period after the wait. clk_o never produces a high or low phase shorter than the shorter half period of the two inputs.
- R5: rc_en_o falls in the same cycle that xt_sel_o rises, at most 8 RC edges after the wait ends. From then on, clk_o follows xt_clk_i.
- R6: If bypass_i=1 at the command, xt_en_o stays 0, the wait is skipped, and clk_o is already low in the RC period after the command edge.
- R7: Once started, the sequence is one-way. Further commands have no effect, in any mode, during or after the switch. xt_sel_o never falls while rst_ni is high. Only asserting rst_ni returns to the RC source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Backup-domain asynchronous reset, active low |
| rc_clk_i | input | 1 | Internal RC oscillator clock |
| xt_clk_i | input | 1 | Crystal oscillator output (or external clock in bypass) |
| cmd_we_i | input | 1 | One-cycle select command strobe, RC domain |
| cmd_xtal_i | input | 1 | Crystal-select bit of the command |
| bypass_i | input | 1 | Bypass mode, sampled with the command |
| rc_en_o | output | 1 | RC oscillator enable |
| xt_en_o | output | 1 | Crystal oscillator amplifier enable |
| clk_o | output | 1 | Muxed slow clock |
| xt_sel_o | output | 1 | Status: crystal is the active source |

## Verification
xt_en_o is due at the first RC edge that samples the command. The bench therefore counts RC edges from that edge and compares the enables and the status at each following falling edge.

The output source is checked 5 ns after each rising RC edge. It must be high through edge START_CYCLES and low at edge START_CYCLES+1, or at edge 1 in bypass. The crystal handoff passes through synchronisers, so its length depends on the clock ratio. For that reason the status is only required to stay low up to edge START_CYCLES+1 and to arrive by edge START_CYCLES+8. rc_en_o must be its exact complement on every edge.

A time-based monitor measures every phase of clk_o to catch runt pulses.

// File: rtl/slow_clk_pkg.sv
package slow_clk_pkg;
  typedef enum logic [1:0] {
    ST_RC   = 2'd0,
    ST_WAIT = 2'd1,
    ST_HAND = 2'd2,
    ST_XT   = 2'd3
  } sw_state_e;
endpackage

// File: rtl/slow_clk_sync.sv
module slow_clk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/slow_clk_seq.sv
module slow_clk_seq
  import slow_clk_pkg::*;
#(
  parameter int unsigned START_CYCLES = 8
) (
  input  logic rc_clk_i,
  input  logic rst_ni,
  input  logic cmd_we_i,
  input  logic cmd_xtal_i,
  input  logic bypass_i,
  input  logic xt_on_i,     // crystal gate open, RC domain
  output logic want_xt_o,
  output logic rc_en_o,
  output logic xt_en_o,
  output logic xt_sel_o
);
  localparam int unsigned CW = (START_CYCLES > 1) ? $clog2(START_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(START_CYCLES - 1);

  sw_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          byp_q;

  always_ff @(posedge rc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RC;
      cnt_q   <= '0;
      byp_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RC: if (cmd_we_i && cmd_xtal_i) begin
          byp_q   <= bypass_i;
          cnt_q   <= '0;
          state_q <= bypass_i ? ST_HAND : ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q == LAST) state_q <= ST_HAND;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_HAND: if (xt_on_i) state_q <= ST_XT;
        default: state_q <= ST_XT;
      endcase
    end
  end

  assign want_xt_o = (state_q == ST_HAND) || (state_q == ST_XT);
  assign rc_en_o   = (state_q != ST_XT);
  assign xt_en_o   = (state_q != ST_RC) && !byp_q;
  assign xt_sel_o  = (state_q == ST_XT);
endmodule

// File: rtl/slow_clk_gmux.sv
module slow_clk_gmux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic rst_ni,
  input  logic rc_clk_i,
  input  logic xt_clk_i,
  input  logic want_xt_i,
  output logic rc_gate_o,
  output logic xt_gate_o,
  output logic clk_o
);
  logic rc_gate_q, xt_gate_q, xt_req_sync;

  // RC gate closes on a falling RC edge, never reopens without reset
  always_ff @(negedge rc_clk_i or negedge rst_ni) begin
    if (!rst_ni) rc_gate_q <= 1'b1;
    else         rc_gate_q <= rc_gate_q & ~want_xt_i;
  end

  slow_clk_sync #(.STAGES(SYNC_STAGES)) u_sync_xt (
    .clk_i (xt_clk_i),
    .rst_ni(rst_ni),
    .d_i   (want_xt_i & ~rc_gate_q),
    .q_o   (xt_req_sync)
  );

  // crystal gate opens on a falling crystal edge
  always_ff @(negedge xt_clk_i or negedge rst_ni) begin
    if (!rst_ni) xt_gate_q <= 1'b0;
    else         xt_gate_q <= xt_req_sync;
  end

  assign rc_gate_o = rc_gate_q;
  assign xt_gate_o = xt_gate_q;
  assign clk_o     = (rc_clk_i & rc_gate_q) | (xt_clk_i & xt_gate_q);
endmodule

// File: rtl/slow_clk_switch.sv
module slow_clk_switch #(
  parameter int unsigned START_CYCLES = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic rst_ni,
  input  logic rc_clk_i,
  input  logic xt_clk_i,
  input  logic cmd_we_i,
  input  logic cmd_xtal_i,
  input  logic bypass_i,
  output logic rc_en_o,
  output logic xt_en_o,
  output logic clk_o,
  output logic xt_sel_o
);
  logic want_xt, rc_gate, xt_gate, xt_on_rc;

  slow_clk_seq #(.START_CYCLES(START_CYCLES)) u_seq (
    .rc_clk_i  (rc_clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (cmd_we_i),
    .cmd_xtal_i(cmd_xtal_i),
    .bypass_i  (bypass_i),
    .xt_on_i   (xt_on_rc),
    .want_xt_o (want_xt),
    .rc_en_o   (rc_en_o),
    .xt_en_o   (xt_en_o),
    .xt_sel_o  (xt_sel_o)
  );

  slow_clk_sync #(.STAGES(SYNC_STAGES)) u_sync_rc (
    .clk_i (rc_clk_i),
    .rst_ni(rst_ni),
    .d_i   (xt_gate),
    .q_o   (xt_on_rc)
  );

  slow_clk_gmux #(.SYNC_STAGES(SYNC_STAGES)) u_gmux (
    .rst_ni   (rst_ni),
    .rc_clk_i (rc_clk_i),
    .xt_clk_i (xt_clk_i),
    .want_xt_i(want_xt),
    .rc_gate_o(rc_gate),
    .xt_gate_o(xt_gate),
    .clk_o    (clk_o)
  );
endmodule

// File: rtl/slow_clk_switch_chk.sv
module slow_clk_switch_chk #(
  parameter int unsigned START_CYCLES = 8
) (
  input logic rst_ni,
  input logic rc_clk_i,
  input logic rc_en_o,
  input logic xt_en_o,
  input logic xt_sel_o,
  input logic want_xt,
  input logic rc_gate,
  input logic xt_gate
);
  int unsigned wait_cnt;

  always_ff @(posedge rc_clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wait_cnt <= 0;
    else if (xt_en_o && !want_xt) wait_cnt <= wait_cnt + 1;
  end

  p_bbm_r4: assert property (@(posedge rc_clk_i) disable iff (!rst_ni)
    !(rc_gate && xt_gate));

  p_wait_len_r3: assert property (@(posedge rc_clk_i) disable iff (!rst_ni)
    ($rose(want_xt) && xt_en_o) |-> (wait_cnt == START_CYCLES));

  p_rc_gate_off_r5: assert property (@(posedge rc_clk_i) disable iff (!rst_ni)
    !rc_en_o |-> !rc_gate);

  p_sel_sticky_r7: assert property (@(posedge rc_clk_i) disable iff (!rst_ni)
    xt_sel_o |=> xt_sel_o);

  p_xt_en_sticky_r2: assert property (@(posedge rc_clk_i) disable iff (!rst_ni)
    xt_en_o |=> xt_en_o);

  p_sel_needs_gate_r5: assert property (@(posedge rc_clk_i) disable iff (!rst_ni)
    $rose(xt_sel_o) |-> xt_gate);
endmodule

bind slow_clk_switch slow_clk_switch_chk #(.START_CYCLES(START_CYCLES)) u_chk (
  .rst_ni  (rst_ni),
  .rc_clk_i(rc_clk_i),
  .rc_en_o (rc_en_o),
  .xt_en_o (xt_en_o),
  .xt_sel_o(xt_sel_o),
  .want_xt (want_xt),
  .rc_gate (rc_gate),
  .xt_gate (xt_gate)
);

// File: tb/slow_clk_switch_tb.sv
`timescale 1ns/1ps
module slow_clk_switch_tb;
  localparam int N = 8;
  localparam real RC_HALF = 10.0;  // 50 MHz
  localparam real XT_HALF = 13.0;

  logic rst_ni = 1'b0, rc_clk = 1'b0, xt_clk = 1'b0;
  logic cmd_we = 1'b0, cmd_xtal = 1'b0, bypass = 1'b0;
  logic rc_en, xt_en, clk_out, xt_sel;
  int   n_run = 0, n_fail = 0, runts = 0;
  bit   mon_en = 1'b0, finished = 1'b0;
  realtime t_edge = 0;

  always #(RC_HALF) rc_clk = ~rc_clk;
  always #(XT_HALF) xt_clk = ~xt_clk;

  slow_clk_switch #(.START_CYCLES(N)) u_dut (
    .rst_ni(rst_ni), .rc_clk_i(rc_clk), .xt_clk_i(xt_clk),
    .cmd_we_i(cmd_we), .cmd_xtal_i(cmd_xtal), .bypass_i(bypass),
    .rc_en_o(rc_en), .xt_en_o(xt_en), .clk_o(clk_out), .xt_sel_o(xt_sel)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // R4 runt monitor: every phase of clk_o at least the shorter half period
  always @(clk_out) begin
    if (mon_en && ($realtime - t_edge) < RC_HALF - 0.5) runts++;
    t_edge = $realtime;
  end

  task automatic follow_rc(input string req);
    @(posedge rc_clk); #5; chk(req, clk_out, 1'b1);
    @(negedge rc_clk); #5; chk(req, clk_out, 1'b0);
  endtask

  task automatic follow_xt(input string req);
    for (int i = 0; i < 4; i++) begin
      @(posedge xt_clk); #3; chk(req, clk_out, 1'b1);
      @(negedge xt_clk); #3; chk(req, clk_out, 1'b0);
    end
  endtask

  // run switch sequence; reference model counts RC edges k from command edge
  task automatic run_switch(input bit byp, input string req);
    int  wait_n = byp ? 0 : N;
    bit  seen = 1'b0;
    int  k_sel = -1;
    @(negedge rc_clk);
    cmd_we = 1'b1; cmd_xtal = 1'b1; bypass = byp;
    @(posedge rc_clk);
    @(negedge rc_clk); cmd_we = 1'b0; bypass = 1'b0;
    for (int k = 1; k <= wait_n + 10; k++) begin
      @(posedge rc_clk); #5;
      if (k <= wait_n) chk({req, " R3 rc source"}, clk_out, 1'b1);
      else if (k == wait_n + 1) chk({req, " R4 low in handoff"}, clk_out, 1'b0);
      @(negedge rc_clk); #1;
      chk(byp ? "R6 xt_en low" : "R2 xt_en high", xt_en, !byp);
      chk("R5 rc_en complement", rc_en, !xt_sel);
      if (k <= wait_n + 1) chk("R3 no early status", xt_sel, 1'b0);
      if (seen) chk("R7 status sticky", xt_sel, 1'b1);
      if (xt_sel && !seen) begin seen = 1'b1; k_sel = k; end
      // R7 repeated command with changed bits must be ignored
      if (k == 3) begin cmd_we = 1'b1; cmd_xtal = 1'b1; bypass = !byp; end
      if (k == 4) begin cmd_we = 1'b0; bypass = 1'b0; end
    end
    chk("R5 status by deadline", seen && (k_sel <= wait_n + 8), 1'b1);
  endtask

  initial begin
    #(200000.0 * 2 * RC_HALF);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #33;
    chk("R1 rc_en in reset", rc_en, 1'b1);
    chk("R1 xt_en in reset", xt_en, 1'b0);
    chk("R1 status in reset", xt_sel, 1'b0);
    @(negedge rc_clk); rst_ni = 1'b1;
    follow_rc("R1 clk follows rc");
    chk("R1 rc_en after reset", rc_en, 1'b1);
    mon_en = 1'b1;

    // R2 command without crystal bit is ignored
    @(negedge rc_clk); cmd_we = 1'b1; cmd_xtal = 1'b0;
    @(negedge rc_clk); cmd_we = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge rc_clk); #1;
      chk("R2 no-xtal cmd ignored", xt_en, 1'b0);
    end
    follow_rc("R2 still on rc");

    run_switch(1'b0, "normal");
    follow_xt("R5 clk follows xt");

    // R7 command after completion
    @(negedge rc_clk); cmd_we = 1'b1; cmd_xtal = 1'b1;
    @(negedge rc_clk); cmd_we = 1'b0;
    repeat (4) @(negedge rc_clk);
    chk("R7 status after late cmd", xt_sel, 1'b1);
    chk("R7 rc stays off", rc_en, 1'b0);
    follow_xt("R7 still on xt");

    // R7 only reset returns to RC
    mon_en = 1'b0;
    @(negedge rc_clk); rst_ni = 1'b0; #1;
    chk("R7 reset rc_en", rc_en, 1'b1);
    chk("R7 reset status", xt_sel, 1'b0);
    chk("R7 reset xt_en", xt_en, 1'b0);
    @(negedge rc_clk); rst_ni = 1'b1;
    follow_rc("R7 back on rc");
    mon_en = 1'b1;

    run_switch(1'b1, "bypass R6");
    follow_xt("R6 clk follows ext clock");

    chk("R4 no runt phase", runts == 0, 1'b1);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule